// File: doc/BRIEF.md
# NAND Data Phase Strobe Timer

This block runs the data phase of an asynchronous NAND flash access on behalf of a host. A single-cycle host request either reads one 16-bit word from the flash bus or writes one. The block then drives the active-low chip-select, read-enable and write-enable pins with edges placed by programmable cycle counts. A request starts an access if its address equals the dedicated data port address, or if it falls anywhere in the chip-select region, which is selected by the upper address bits. Requests to any other address are dropped.

Every edge is set by its own count, measured in controller clock cycles from the start of the access. Cycle 0 is the first cycle after the clock edge that accepts the request. On a read, the bus is sampled at a programmed cycle. That cycle may lie after read-enable has been released, which lets the read cycle be shortened to the device's data-hold window. On a write, the block drives the latched word onto the bus only while write-enable is low. The address latch enable and command latch enable pins stay inactive throughout, because command and address phases belong to another block. The timing inputs are taken to be stable while an access is in flight.

Top module: `nand_dphase_engine`

## Requirements
- R1: A request with `req_valid` high while idle starts an access when `req_addr` equals the data port address or when its upper bits `req_addr[AW-1:RW]` equal the region tag. Any other address leaves `busy` low and every strobe high.
- R2: `busy` is high for exactly L cycles, numbered 0 to L-1. L is `cfg_rd_len` for reads and `cfg_wr_len` for writes, and a value of 0 counts as 1. A request made while `busy` is high is ignored and does not start a second access.
- R3: `nand_cs_n` is low in exactly the cycles i with `cfg_cs_on` <= i < off. Here off is `cfg_cs_rd_off` on reads and `cfg_cs_wr_off` on writes. It is high whenever the block is idle.
- R4: On a read, `nand_re_n` is low in exactly the cycles with `cfg_re_on` <= i < `cfg_re_off`. It stays high during writes.
- R5: On a write, `nand_we_n` is low in exactly the cycles with `cfg_we_on` <= i < `cfg_we_off`. It stays high during reads.
- R6: A read samples `dq_i` at the end of cycle C = min(`cfg_rd_sample`, L-1), even when that cycle lies after read-enable has gone high. In cycle C+1 it presents the word on `rd_data` with a one-cycle `rd_valid` pulse, exactly once per read.
- R7: `dq_oe` is high exactly in the cycles where `nand_we_n` is low on a write, with `dq_o` equal to the requested write word. It stays low during reads.
- R8: `nand_ale` and `nand_cle` are low at all times.
- R9: If a strobe used by the access has on-count >= off-count, that strobe never goes low in that access. `cfg_err` is then high for every cycle of that access, and low at all other times.
- R10: During reset and in the first idle cycle after it, all three strobes are high and `busy`, `rd_valid`, `dq_oe` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe, one cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Host address, decoded against the port address and region tag |
| req_wdata | input | DW | Word to write |
| busy | output | 1 | Access in progress; new requests are ignored |
| cfg_cs_on | input | TW | Chip-select assert cycle |
| cfg_cs_rd_off | input | TW | Chip-select release cycle for reads |
| cfg_cs_wr_off | input | TW | Chip-select release cycle for writes |
| cfg_re_on | input | TW | Read-enable assert cycle |
| cfg_re_off | input | TW | Read-enable release cycle |
| cfg_we_on | input | TW | Write-enable assert cycle |
| cfg_we_off | input | TW | Write-enable release cycle |
| cfg_rd_sample | input | TW | Cycle whose end samples the bus on reads |
| cfg_rd_len | input | TW | Read access length in cycles |
| cfg_wr_len | input | TW | Write access length in cycles |
| cfg_err | output | 1 | Empty strobe window in the current access |
| rd_valid | output | 1 | Read word valid, one-cycle pulse |
| rd_data | output | DW | Captured read word |
| nand_cs_n | output | 1 | Chip-select, active low |
| nand_re_n | output | 1 | Read-enable, active low |
| nand_we_n | output | 1 | Write-enable, active low |
| nand_ale | output | 1 | Address latch enable, held inactive |
| nand_cle | output | 1 | Command latch enable, held inactive |
| dq_i | input | DW | Flash data bus input |
| dq_o | output | DW | Flash data bus output value |
| dq_oe | output | 1 | Flash data bus output enable |

## Verification
The assertions check these properties on every cycle: the strobes are high whenever the block is idle, read-enable never moves during a write, and write-enable and the bus driver never move during a read. They also check that the cycle counter starts at zero, steps by one and stays below the access length, that a read word appears at most once in a row and only after a read cycle, and that the error flag is seen only while busy. The exact cycle of each strobe edge for a given setting, the sampling point that follows read-enable release, and the clamping of a late sample point can only be shown by the bench's scenarios. The same holds for the address decode, the dropping of requests made while busy, and a length of zero.

// File: rtl/nand_dphase_pkg.sv
// Package: shared types for the NAND data phase strobe timer.
// Assumes nothing beyond being compiled before the modules that import it.
package nand_dphase_pkg;

    // Number of timed strobes (chip-select, read-enable, write-enable).
    localparam int unsigned NUM_STROBES = 3;

    // Index of each strobe in the generated strobe array.
    typedef enum logic [1:0] {
        STB_CS = 2'd0,
        STB_RE = 2'd1,
        STB_WE = 2'd2
    } strobe_idx_e;

    // Per-cycle control produced by the sequencer.
    typedef struct packed {
        logic load;    // request accepted at this edge
        logic adv;     // access continues into the next cycle
        logic done;    // last cycle of the access ends at this edge
        logic dir_wr;  // direction of the access being loaded or running
    } seq_ctl_t;

endpackage

// File: rtl/nand_dphase_seq.sv
// Module: access sequencer. Holds the busy flag, the access direction and
// the cycle index, and tells the strobe and capture logic when an access
// is loaded, advances or ends.
// Assumes: the start input is already gated with !busy by the caller, and
// the length inputs are stable while busy. A length of 0 is run as 1 cycle.
module nand_dphase_seq
    import nand_dphase_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [TW-1:0] rd_len,
    input  logic [TW-1:0] wr_len,
    output logic          busy,
    output logic          is_wr,
    output logic [TW-1:0] cnt,
    output logic [TW-1:0] nxt,
    output logic [TW-1:0] len_eff,
    output seq_ctl_t      ctl
);

    localparam int CW = TW + 1;

    logic [TW-1:0] len_raw;
    logic          last;

    // Pick the length of the running access, or of the one being loaded.
    always_comb begin
        if (busy) len_raw = is_wr ? wr_len : rd_len;
        else      len_raw = start_wr ? wr_len : rd_len;
        len_eff = (len_raw == '0) ? TW'(1) : len_raw;
    end

    // Decide whether the current cycle is the final one of the access.
    assign last = (CW'(cnt) + CW'(1)) >= CW'(len_eff);

    // Build the control word and the cycle index of the next cycle.
    always_comb begin
        ctl.load   = start && !busy;
        ctl.adv    = busy && !last;
        ctl.done   = busy && last;
        ctl.dir_wr = busy ? is_wr : start_wr;
        nxt        = busy ? (cnt + TW'(1)) : '0;
    end

    // Track busy, direction and cycle index across the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            is_wr <= 1'b0;
            cnt   <= '0;
        end else if (ctl.load) begin
            busy  <= 1'b1;
            is_wr <= start_wr;
            cnt   <= '0;
        end else if (ctl.adv) begin
            cnt   <= nxt;
        end else if (ctl.done) begin
            busy  <= 1'b0;
            cnt   <= '0;
        end
    end

endmodule

// File: rtl/nand_dphase_strobe.sv
// Module: one registered active-low strobe. In each access cycle i it is
// low when enabled and on_t <= i < off_t, and high otherwise. The output
// comes straight from a flop, so it cannot glitch.
// Assumes: nxt is the index of the cycle that follows the edge, and
// on_t/off_t are stable while the access runs.
module nand_dphase_strobe #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          done,
    input  logic          en,
    input  logic [TW-1:0] nxt,
    input  logic [TW-1:0] on_t,
    input  logic [TW-1:0] off_t,
    output logic          strobe_n
);

    logic in_win;

    // Test whether the coming cycle falls inside the programmed window.
    assign in_win = en && (nxt >= on_t) && (nxt < off_t);

    // Register the strobe level for the coming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    strobe_n <= 1'b1;
        else if (step) strobe_n <= !in_win;
        else if (done) strobe_n <= 1'b1;
    end

endmodule

// File: rtl/nand_dphase_capture.sv
// Module: read data capture. It samples the bus at the end of the sample
// cycle. That cycle is clamped to the last cycle of the access, so every
// read yields exactly one word. The word is presented with a one-cycle
// valid pulse.
// Assumes: cnt and len_eff come from the sequencer, and the sample cycle
// input is stable during the access.
module nand_dphase_capture #(
    parameter int TW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          is_wr,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] len_eff,
    input  logic [TW-1:0] sample_at,
    input  logic [DW-1:0] dq_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic [TW-1:0] cap_idx;
    logic          fire;

    // Clamp the sample cycle to the final cycle of the access.
    assign cap_idx = (sample_at >= len_eff) ? (len_eff - TW'(1)) : sample_at;
    assign fire    = busy && !is_wr && (cnt == cap_idx);

    // Register the sampled word and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= fire;
            if (fire) rd_data <= dq_i;
        end
    end

endmodule

// File: rtl/nand_dphase_engine.sv
// Module: top of the NAND data phase strobe timer. It decodes host
// requests, runs the sequencer, generates the three timed strobes,
// captures read data, drives write data and flags empty strobe windows.
// Assumes: timing inputs are stable during an access, and the host retries
// any request that is made while busy.
module nand_dphase_engine
    import nand_dphase_pkg::*;
#(
    parameter int                AW         = 16,
    parameter int                RW         = 12,
    parameter int                DW         = 16,
    parameter int                TW         = 5,
    parameter logic [AW-1:0]     PORT_ADDR  = 16'h007C,
    parameter logic [AW-RW-1:0]  REGION_TAG = 4'h2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    input  logic [TW-1:0] cfg_cs_on,
    input  logic [TW-1:0] cfg_cs_rd_off,
    input  logic [TW-1:0] cfg_cs_wr_off,
    input  logic [TW-1:0] cfg_re_on,
    input  logic [TW-1:0] cfg_re_off,
    input  logic [TW-1:0] cfg_we_on,
    input  logic [TW-1:0] cfg_we_off,
    input  logic [TW-1:0] cfg_rd_sample,
    input  logic [TW-1:0] cfg_rd_len,
    input  logic [TW-1:0] cfg_wr_len,
    output logic          cfg_err,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          nand_cs_n,
    output logic          nand_re_n,
    output logic          nand_we_n,
    output logic          nand_ale,
    output logic          nand_cle,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);

    logic          hit_port;
    logic          hit_region;
    logic          accept;
    logic          is_wr;
    logic [TW-1:0] cnt;
    logic [TW-1:0] nxt;
    logic [TW-1:0] len_eff;
    seq_ctl_t      ctl;
    logic          err_rd;
    logic          err_wr;
    logic [DW-1:0] wdata_q;

    logic [TW-1:0]    on_arr  [NUM_STROBES];
    logic [TW-1:0]    off_arr [NUM_STROBES];
    logic [NUM_STROBES-1:0] en_vec;
    logic [NUM_STROBES-1:0] stb_n;

    // Decode the data port location and the chip-select region.
    assign hit_port   = (req_addr == PORT_ADDR);
    assign hit_region = (req_addr[AW-1:RW] == REGION_TAG);
    assign accept     = req_valid && (hit_port || hit_region);

    nand_dphase_seq #(.TW(TW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_wr (req_write),
        .rd_len   (cfg_rd_len),
        .wr_len   (cfg_wr_len),
        .busy     (busy),
        .is_wr    (is_wr),
        .cnt      (cnt),
        .nxt      (nxt),
        .len_eff  (len_eff),
        .ctl      (ctl)
    );

    // Route each strobe's window and direction enable for this access.
    always_comb begin
        on_arr[int'(STB_CS)]  = cfg_cs_on;
        off_arr[int'(STB_CS)] = ctl.dir_wr ? cfg_cs_wr_off : cfg_cs_rd_off;
        en_vec[int'(STB_CS)]  = 1'b1;
        on_arr[int'(STB_RE)]  = cfg_re_on;
        off_arr[int'(STB_RE)] = cfg_re_off;
        en_vec[int'(STB_RE)]  = !ctl.dir_wr;
        on_arr[int'(STB_WE)]  = cfg_we_on;
        off_arr[int'(STB_WE)] = cfg_we_off;
        en_vec[int'(STB_WE)]  = ctl.dir_wr;
    end

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        nand_dphase_strobe #(.TW(TW)) u_stb (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (ctl.load || ctl.adv),
            .done     (ctl.done),
            .en       (en_vec[g]),
            .nxt      (nxt),
            .on_t     (on_arr[g]),
            .off_t    (off_arr[g]),
            .strobe_n (stb_n[g])
        );
    end

    assign nand_cs_n = stb_n[int'(STB_CS)];
    assign nand_re_n = stb_n[int'(STB_RE)];
    assign nand_we_n = stb_n[int'(STB_WE)];
    assign nand_ale  = 1'b0;
    assign nand_cle  = 1'b0;

    nand_dphase_capture #(.TW(TW), .DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .is_wr     (is_wr),
        .cnt       (cnt),
        .len_eff   (len_eff),
        .sample_at (cfg_rd_sample),
        .dq_i      (dq_i),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Find empty windows among the strobes each direction uses.
    assign err_rd = (cfg_cs_on >= cfg_cs_rd_off) || (cfg_re_on >= cfg_re_off);
    assign err_wr = (cfg_cs_on >= cfg_cs_wr_off) || (cfg_we_on >= cfg_we_off);

    // Hold the configuration error flag for the length of the access.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_err <= 1'b0;
        else if (ctl.load) cfg_err <= req_write ? err_wr : err_rd;
        else if (ctl.done) cfg_err <= 1'b0;
    end

    // Latch the write word when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        wdata_q <= '0;
        else if (ctl.load) wdata_q <= req_wdata;
    end

    assign dq_o  = wdata_q;
    assign dq_oe = !nand_we_n;

endmodule

// File: rtl/nand_dphase_checker.sv
// Module: cycle-by-cycle properties of the NAND data phase strobe timer,
// attached to the top module by the bind below.
// Assumes: it sees the top's ports and its sequencer state signals.
module nand_dphase_checker #(
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          is_wr,
    input logic [TW-1:0] cnt,
    input logic [TW-1:0] len_eff,
    input logic          nand_cs_n,
    input logic          nand_re_n,
    input logic          nand_we_n,
    input logic          dq_oe,
    input logic          rd_valid,
    input logic          cfg_err
);

    p_idle_strobes_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_cs_n && nand_re_n && nand_we_n && !dq_oe));

    p_re_quiet_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_wr) |-> nand_re_n);

    p_we_quiet_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_wr) |-> (nand_we_n && !dq_oe));

    p_count_below_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < len_eff));

    p_count_starts_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == '0));

    p_count_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cnt == $past(cnt) + TW'(1)));

    p_word_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy && !is_wr));

    p_word_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_err_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> busy);

endmodule

bind nand_dphase_engine nand_dphase_checker #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .is_wr     (is_wr),
    .cnt       (cnt),
    .len_eff   (len_eff),
    .nand_cs_n (nand_cs_n),
    .nand_re_n (nand_re_n),
    .nand_we_n (nand_we_n),
    .dq_oe     (dq_oe),
    .rd_valid  (rd_valid),
    .cfg_err   (cfg_err)
);

// File: tb/nand_dphase_engine_bench.sv
`timescale 1ns/1ps
module nand_dphase_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy;
    logic [4:0]  cfg_cs_on = '0, cfg_cs_rd_off = '0, cfg_cs_wr_off = '0;
    logic [4:0]  cfg_re_on = '0, cfg_re_off = '0, cfg_we_on = '0, cfg_we_off = '0;
    logic [4:0]  cfg_rd_sample = '0, cfg_rd_len = '0, cfg_wr_len = '0;
    logic        cfg_err, rd_valid;
    logic [15:0] rd_data;
    logic        nand_cs_n, nand_re_n, nand_we_n, nand_ale, nand_cle;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [15:0] exp_q [$];

    localparam logic [15:0] PORT  = 16'h007C;
    localparam logic [15:0] REGN  = 16'h2ABC;
    localparam logic [15:0] MISS  = 16'h5000;

    always #4 clk = ~clk;

    nand_dphase_engine u_nand_dphase_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .cfg_cs_on(cfg_cs_on), .cfg_cs_rd_off(cfg_cs_rd_off), .cfg_cs_wr_off(cfg_cs_wr_off),
        .cfg_re_on(cfg_re_on), .cfg_re_off(cfg_re_off), .cfg_we_on(cfg_we_on),
        .cfg_we_off(cfg_we_off), .cfg_rd_sample(cfg_rd_sample), .cfg_rd_len(cfg_rd_len),
        .cfg_wr_len(cfg_wr_len), .cfg_err(cfg_err), .rd_valid(rd_valid), .rd_data(rd_data),
        .nand_cs_n(nand_cs_n), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
        .nand_ale(nand_ale), .nand_cle(nand_cle), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input int i, input int on_t, input int off_t);
        return (i >= on_t) && (i < off_t);
    endfunction

    // Monitor: pop the expected read word whenever the design presents one (R6).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected rd_valid", 32'(rd_data), 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R6 read word", 32'(rd_data), 32'(e));
            end
        end
    end

    // Driver: run one access and check every cycle against the requirements.
    task automatic do_access(input bit wr, input logic [15:0] addr,
                             input logic [15:0] wd, input bit poke);
        int len, coff, cap;
        bit err;
        logic [15:0] base;
        len  = wr ? int'(cfg_wr_len) : int'(cfg_rd_len);
        if (len == 0) len = 1;
        coff = wr ? int'(cfg_cs_wr_off) : int'(cfg_cs_rd_off);
        cap  = (int'(cfg_rd_sample) >= len) ? len - 1 : int'(cfg_rd_sample);
        err  = wr ? ((cfg_cs_on >= cfg_cs_wr_off) || (cfg_we_on >= cfg_we_off))
                  : ((cfg_cs_on >= cfg_cs_rd_off) || (cfg_re_on >= cfg_re_off));
        base = wd ^ 16'hA55A;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        if (!wr) exp_q.push_back(base ^ 16'(cap));
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i <= len; i++) begin
            dq_i = base ^ 16'(i);
            if (i < len) begin
                bit ecs, ere, ewe;
                ecs = in_win(i, int'(cfg_cs_on), coff);
                ere = !wr && in_win(i, int'(cfg_re_on), int'(cfg_re_off));
                ewe = wr && in_win(i, int'(cfg_we_on), int'(cfg_we_off));
                check(busy == 1'b1, "R2 busy during access", 32'(busy), 32'h1);
                check(nand_cs_n == !ecs, "R3 chip-select", 32'(nand_cs_n), 32'(!ecs));
                check(nand_re_n == !ere, "R4 read-enable", 32'(nand_re_n), 32'(!ere));
                check(nand_we_n == !ewe, "R5 write-enable", 32'(nand_we_n), 32'(!ewe));
                check(dq_oe == ewe, "R7 bus enable", 32'(dq_oe), 32'(ewe));
                if (ewe) check(dq_o == wd, "R7 bus word", 32'(dq_o), 32'(wd));
                check(!nand_ale && !nand_cle, "R8 latch enables",
                      32'({nand_ale, nand_cle}), 32'h0);
                check(cfg_err == err, "R9 config error", 32'(cfg_err), 32'(err));
            end else begin
                check(busy == 1'b0, "R2 busy ends after L cycles", 32'(busy), 32'h0);
                check(nand_cs_n && nand_re_n && nand_we_n, "R3 strobes released",
                      32'({nand_cs_n, nand_re_n, nand_we_n}), 32'h7);
                check(cfg_err == 1'b0, "R9 error cleared", 32'(cfg_err), 32'h0);
            end
            if (poke && i == 1) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = PORT;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic set_read(input int cson, input int csoff, input int reon,
                            input int reoff, input int samp, input int rlen);
        cfg_cs_on = 5'(cson); cfg_cs_rd_off = 5'(csoff); cfg_re_on = 5'(reon);
        cfg_re_off = 5'(reoff); cfg_rd_sample = 5'(samp); cfg_rd_len = 5'(rlen);
    endtask

    task automatic set_write(input int cson, input int csoff, input int weon,
                             input int weoff, input int wlen);
        cfg_cs_on = 5'(cson); cfg_cs_wr_off = 5'(csoff); cfg_we_on = 5'(weon);
        cfg_we_off = 5'(weoff); cfg_wr_len = 5'(wlen);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(negedge clk);
        check(nand_cs_n && nand_re_n && nand_we_n, "R10 strobes in reset",
              32'({nand_cs_n, nand_re_n, nand_we_n}), 32'h7);
        check(!busy && !rd_valid && !dq_oe && !cfg_err, "R10 flags in reset",
              32'({busy, rd_valid, dq_oe, cfg_err}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(nand_cs_n && nand_re_n && nand_we_n && !busy, "R10 idle after reset",
              32'({nand_cs_n, nand_re_n, nand_we_n, busy}), 32'he);

        // R6: sample after read-enable release, via the data port (R1).
        set_read(0, 7, 1, 4, 5, 7);
        do_access(1'b0, PORT, 16'h1234, 1'b0);

        // R1 region read, sample while read-enable low, R2 poke while busy.
        set_read(1, 6, 2, 5, 3, 6);
        do_access(1'b0, REGN, 16'h0F0F, 1'b1);

        // R5/R7 write through the port, then through the region.
        set_write(0, 6, 1, 4, 6);
        do_access(1'b1, PORT, 16'hBEEF, 1'b0);
        set_write(1, 5, 2, 3, 5);
        do_access(1'b1, REGN, 16'hC0DE, 1'b1);

        // R9: empty write-enable window.
        set_write(0, 4, 3, 3, 5);
        do_access(1'b1, REGN, 16'h5555, 1'b0);

        // R9: empty read-enable window.
        set_read(0, 4, 4, 2, 1, 5);
        do_access(1'b0, PORT, 16'h7777, 1'b0);

        // R6: sample point beyond the access is clamped to the last cycle.
        set_read(0, 5, 0, 3, 20, 5);
        do_access(1'b0, PORT, 16'h3C3C, 1'b0);

        // R2: zero length runs one cycle.
        set_read(0, 1, 0, 1, 0, 0);
        do_access(1'b0, REGN, 16'h9999, 1'b0);

        // R1: an address outside both targets is dropped.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = MISS;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0, "R1 miss leaves idle", 32'(busy), 32'h0);
        check(nand_cs_n == 1'b1, "R1 miss keeps chip-select high", 32'(nand_cs_n), 32'h1);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && !rd_valid, "R1 miss starts nothing",
              32'({busy, rd_valid}), 32'h0);

        check(exp_q.size() == 0, "R6 all read words delivered", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule